// File: doc/BRIEF.md
# Looping Status Register Shifter

This block answers the status-read command on the device side of a serial flash interface. While chip select is low it watches the first eight data-in bits clocked on rising serial-clock edges. If those bits form the status opcode, it drives a one-byte status word on the serial output, one bit per falling serial-clock edge, most significant bit first. The byte starts again as long as chip select stays low and the serial clock keeps toggling. A fresh copy of the status is taken at the start of every byte, so a long poll always reflects current conditions.

The serial clock, chip select and data-in pins are treated as ordinary inputs sampled by a faster system clock. The block finds the serial-clock edges itself. The status word holds four fields: a ready flag (the inverse of the live busy input), a compare-result flag, a fixed density code, and three reserved bits. The ready bit is wired straight through from the busy input whenever it is the bit on the output. This lets a host park the serial clock low on that bit and see the output change as soon as the device stops being busy. Output enable drops as soon as chip select goes high.

Top module: `stat_shifter`

## Requirements
- R1: After reset, and whenever cs_n is high, so_oe is 0.
- R2: An opcode whose low seven bits are 1010111 (57h or D7h), shifted in MSB first on eight rising sck edges, sets so_oe to 1 and shows status bit 7 from the first falling sck edge after the eighth rising edge.
- R3: Any other opcode leaves so_oe at 0 for all later sck edges until cs_n goes high.
- R4: Each later falling sck edge moves the output to the next lower status bit, so the byte goes out MSB first over eight falling edges.
- R5: Status byte layout: bit 7 = NOT busy, bit 6 = cmp_flag, bits 5:3 = density (density[2] in bit 5), bits 2:0 = 0.
- R6: After bit 0, the next falling sck edge starts the byte again at bit 7, with no limit while cs_n stays low.
- R7: cmp_flag and density are captured on the falling edge that starts each byte. A change during a byte first shows up in the next byte.
- R8: While bit 7 is the bit on the output, so follows NOT busy with no sck edge needed, whether or not sck is parked low.
- R9: cs_n going high drops so_oe in the same cycle and clears the command receiver, so the next low period of cs_n starts a new opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, sampled by clk |
| si | input | 1 | Serial data in, taken on rising sck |
| busy | input | 1 | Live device busy flag |
| cmp_flag | input | 1 | Compare-result flag |
| density | input | 3 | Fixed density code |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so (0 means tristated) |

## Verification
The assertions assume that sck, si and cs_n change only between clk edges. They also assume that each sck level lasts at least one clk cycle, so that a single rising or falling edge is seen per transition. The bench holds every sck level for four clk cycles and changes the serial inputs and status flags on the falling clk edge. It waits several clk cycles after each serial edge before it samples the outputs. cs_n is changed only while sck is low, and busy changes are made while bit 7 is on the output, so the live path can be seen directly.

// File: rtl/stsh_pkg.sv
package stsh_pkg;
  localparam int STAT_W = 8;
  localparam int RSV_W  = 3;
  localparam int DENS_W = STAT_W - 2 - RSV_W;
  localparam int POS_W  = $clog2(STAT_W);
  localparam int OP_W   = 8;
  localparam int CNT_W  = $clog2(OP_W + 1);
  localparam logic [OP_W-2:0] STATUS_OP_LOW = 7'h57;

  // assemble the status word: ready, compare, density, reserved zeros
  function automatic logic [STAT_W-1:0] pack_status(
    input logic busy_i, input logic cmp_i, input logic [DENS_W-1:0] dens_i);
    return {~busy_i, cmp_i, dens_i, {RSV_W{1'b0}}};
  endfunction

  // both opcode forms share the low seven bits
  function automatic logic is_status_op(input logic [OP_W-1:0] op);
    return op[OP_W-2:0] == STATUS_OP_LOW;
  endfunction
endpackage

// File: rtl/stsh_edge.sv
module stsh_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  output logic sck_rise,
  output logic sck_fall
);
  logic sck_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  assign sck_rise = sck & ~sck_q;
  assign sck_fall = ~sck & sck_q;
endmodule

// File: rtl/stsh_opdec.sv
module stsh_opdec
  import stsh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck_rise,
  input  logic si,
  output logic armed
);
  logic [OP_W-1:0]  sh;
  logic [CNT_W-1:0] cnt;
  logic             last_bit;

  assign last_bit = sck_rise && (cnt == CNT_W'(OP_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || cs_n) begin
      sh    <= '0;
      cnt   <= '0;
      armed <= 1'b0;
    end else if (sck_rise && cnt < CNT_W'(OP_W)) begin
      sh  <= {sh[OP_W-2:0], si};
      cnt <= cnt + 1'b1;
      if (last_bit) armed <= is_status_op({sh[OP_W-2:0], si});
    end
  end

  // R3
  armed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !cs_n) |=> armed);
endmodule

// File: rtl/stsh_shift.sv
module stsh_shift
  import stsh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck_fall,
  input  logic              armed,
  input  logic              busy,
  input  logic              cmp_flag,
  input  logic [DENS_W-1:0] density,
  output logic              so,
  output logic              active
);
  logic [STAT_W-1:0] snap;
  logic [POS_W-1:0]  pos;
  logic              byte_start;
  logic              on_msb;

  assign byte_start = sck_fall && armed && (!active || pos == '0);
  assign on_msb     = active && (pos == POS_W'(STAT_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || cs_n) begin
      snap   <= '0;
      pos    <= '0;
      active <= 1'b0;
    end else if (byte_start) begin
      snap   <= pack_status(busy, cmp_flag, density);
      pos    <= POS_W'(STAT_W - 1);
      active <= 1'b1;
    end else if (sck_fall && active) begin
      pos <= pos - 1'b1;
    end
  end

  // bit 7 bypasses the snapshot so a parked poll sees busy clear at once
  always_comb begin
    if (!active)     so = 1'b0;
    else if (on_msb) so = ~busy;
    else             so = snap[pos];
  end

  // R2
  start_after_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(armed));
  // R4
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !cs_n) |=> $stable(pos));
  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && pos < POS_W'(RSV_W)) |-> !so);
  // R7
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_start && !cs_n) |=> $stable(snap));
endmodule

// File: rtl/stat_shifter.sv
module stat_shifter
  import stsh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              busy,
  input  logic              cmp_flag,
  input  logic [DENS_W-1:0] density,
  output logic              so,
  output logic              so_oe
);
  logic sck_rise, sck_fall, armed, active;

  stsh_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sck(sck),
    .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  stsh_opdec u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
    .sck_rise(sck_rise), .si(si), .armed(armed)
  );

  stsh_shift u_sh (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_fall(sck_fall),
    .armed(armed), .busy(busy), .cmp_flag(cmp_flag), .density(density),
    .so(so), .active(active)
  );

  assign so_oe = active & ~cs_n;

  // R9
  cs_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !active);
endmodule

// File: tb/sim_stat_shifter.sv
module sim_stat_shifter;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic busy = 1'b0, cmp_flag = 1'b0;
  logic [2:0] density = 3'd0;
  logic so, so_oe;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stat_shifter u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .busy(busy), .cmp_flag(cmp_flag), .density(density), .so(so), .so_oe(so_oe));

  function automatic logic [7:0] exp_byte(input logic b, input logic c, input logic [2:0] d);
    logic [7:0] r;
    r[7] = !b; r[6] = c; r[5:3] = d; r[2:0] = 3'b000;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    si = b; sck = 1'b1; wclk(4);
    sck = 1'b0; wclk(4);
  endtask

  task automatic send_op(input logic [7:0] op);
    for (int i = 7; i >= 0; i--) pulse(op[i]);
  endtask

  task automatic read_byte(input logic [7:0] e, input string req);
    for (int i = 7; i >= 0; i--) begin
      chk(so_oe === 1'b1 && so === e[i], req, {so_oe, so}, {1'b1, e[i]});
      pulse(1'b0);
    end
  endtask

  task automatic open_cs();
    cs_n = 1'b0; wclk(2);
  endtask

  task automatic close_cs();
    cs_n = 1'b1; wclk(3);
  endtask

  task automatic t_reset();
    chk(so_oe === 1'b0, "R1 reset", so_oe, 0);
  endtask

  task automatic t_basic();
    busy = 0; cmp_flag = 1; density = 3'b101;
    open_cs();
    send_op(8'h57);
    read_byte(exp_byte(0, 1, 3'b101), "R2 R4 R5 first byte");
    read_byte(exp_byte(0, 1, 3'b101), "R6 repeat");
    read_byte(exp_byte(0, 1, 3'b101), "R6 third pass");
    cs_n = 1'b1; #1;
    chk(so_oe === 1'b0, "R9 immediate tristate", so_oe, 0);
    wclk(3);
    chk(so_oe === 1'b0, "R1 cs high", so_oe, 0);
  endtask

  task automatic t_alt();
    busy = 1; cmp_flag = 0; density = 3'b010;
    open_cs();
    send_op(8'hD7);
    read_byte(exp_byte(1, 0, 3'b010), "R2 R5 D7 opcode");
    close_cs();
  endtask

  task automatic t_refresh();
    logic [7:0] old_b, new_b;
    busy = 0; cmp_flag = 0; density = 3'b011;
    old_b = exp_byte(0, 0, 3'b011);
    new_b = exp_byte(0, 1, 3'b100);
    open_cs();
    send_op(8'h57);
    chk(so === old_b[7], "R7 bit7", so, old_b[7]);
    pulse(1'b0);
    cmp_flag = 1; density = 3'b100;
    for (int i = 6; i >= 0; i--) begin
      chk(so === old_b[i], "R7 mid-byte change hidden", so, old_b[i]);
      pulse(1'b0);
    end
    read_byte(new_b, "R7 next byte refreshed");
    close_cs();
  endtask

  task automatic t_park();
    busy = 1; cmp_flag = 1; density = 3'b111;
    open_cs();
    send_op(8'h57);
    chk(so === 1'b0, "R8 busy shown", so, 0);
    busy = 0; wclk(2);
    chk(so === 1'b1, "R8 parked ready", so, 1);
    busy = 1; wclk(2);
    chk(so === 1'b0, "R8 parked busy again", so, 0);
    pulse(1'b0);
    busy = 0; wclk(2);
    chk(so === 1'b1, "R5 bit6 cmp not live", so, 1);
    for (int i = 0; i < 7; i++) pulse(1'b0);
    busy = 1; wclk(2);
    chk(so === 1'b0, "R8 second pass live", so, 0);
    busy = 0; wclk(2);
    chk(so === 1'b1, "R8 second pass ready", so, 1);
    close_cs();
  endtask

  task automatic t_badop();
    busy = 0; cmp_flag = 1; density = 3'b001;
    open_cs();
    send_op(8'h52);
    for (int i = 0; i < 16; i++) begin
      chk(so_oe === 1'b0, "R3 other opcode", so_oe, 0);
      pulse(1'b1);
    end
    close_cs();
    open_cs();
    send_op(8'hD7);
    read_byte(exp_byte(0, 1, 3'b001), "R9 receiver restarted");
    close_cs();
  endtask

  initial begin
    wclk(4);
    rst_n = 1'b1;
    wclk(2);
    t_reset();
    t_basic();
    t_alt();
    t_refresh();
    t_park();
    t_badop();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule